// File: doc/BRIEF.md
# Display Controller Command Parser

This block sits behind the host link of a small graphic display controller. Bytes arrive one per cycle with a flag marking them as command-stream or pixel-data bytes. In the command stream, the block recognises opcodes and gathers the number of argument bytes that each opcode needs. It then updates the configuration it exposes on its outputs. These outputs are the column and row address windows, a bank of single-byte settings, display mode and sleep state, and a write port for two lookup tables (icon drive levels and gray-level pulse widths).

A lock gate can be closed by one short command sequence. While it is closed, the host is ignored until the matching opening sequence arrives. If a pixel-data byte arrives while arguments are still expected, the pending command is abandoned. The physical link timing and the pixel path are outside this block.

Top module: `dcmd_parser`

## Requirements
- R1: After reset every setting slot reads 0 except slot 11 (line count), which reads 127; both windows read 0; the display is asleep; the gate is open; `status` reads 0x40; no strobe is high.
- R2: Opcode 0x15 takes two argument bytes (first, last) for the column window, and 0x75 does the same for the row window. Both window outputs change, and `col_load` or `row_load` pulses for one cycle, only on the cycle after the second byte.
- R3: Eighteen opcodes take one argument, which is stored in a slot: 0x81→0, 0x82→1, 0x90→2, 0x91→3, 0x93→4, 0x94→5, 0x95→6, 0x96→7, 0xA0→8, 0xA1→9, 0xA2→10, 0xA8→11, 0xB1→12, 0xB2→13, 0xB3→14, 0xBB→15, 0xBC→16, 0xBE→17. No other slot changes.
- R4: Opcode 0x92 is followed by 64 bytes. The k-th byte (counting from 0) produces a one-cycle `lut_we` with `lut_tbl`=0, `lut_addr`=k, `lut_data`=the byte.
- R5: Opcode 0xB8 is followed by 15 bytes. The k-th byte produces a `lut_we` with `lut_tbl`=1, `lut_addr`=k+1, so addresses run 1 to 15.
- R6: Opcode 0xAE puts the display to sleep and 0xAF wakes it. `status` bit 6 is 1 while asleep and 0 while awake; all other status bits are 0.
- R7: Opcodes 0xA4 to 0xA7 set `disp_mode` to the opcode's two low bits (0 normal, 1 all lit, 2 all dark, 3 inverted). Opcode 0xB7 pulses `gray_default` for one cycle.
- R8: Opcode 0xFD with argument 0x13 closes the gate and 0xFD with argument 0x12 opens it. Any other argument leaves the gate as it was.
- R9: While the gate is closed, every byte except a 0xFD opcode and its argument is dropped. No setting, window, table, mode or sleep output changes.
- R10: The line-count slot (11) stores the argument with bit 7 cleared, and raises any value below 15 to 15.
- R11: Opcode 0xE3 and every unlisted opcode take no argument and change nothing; the next command byte is decoded as an opcode.
- R12: A pixel-data byte that arrives while arguments are pending ends the pending command. A half-received window is not written, and no further table writes occur. A pixel-data byte with nothing pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_dc | input | 1 | 1 = pixel-data byte, 0 = command-stream byte |
| in_byte | input | 8 | Byte value |
| cfg_regs | output | NSLOT×8 | Single-byte setting slots, slot n in bits [8n+7:8n] |
| col_start | output | 8 | Column window first address |
| col_end | output | 8 | Column window last address |
| row_start | output | 8 | Row window first address |
| row_end | output | 8 | Row window last address |
| col_load | output | 1 | One-cycle pulse when the column window is updated |
| row_load | output | 1 | One-cycle pulse when the row window is updated |
| lut_we | output | 1 | Table write strobe |
| lut_tbl | output | 1 | 0 = icon level table, 1 = gray pulse table |
| lut_addr | output | 6 | Table entry |
| lut_data | output | 8 | Table entry value |
| gray_default | output | 1 | One-cycle pulse requesting the default gray table |
| disp_mode | output | 2 | Display override mode |
| disp_on | output | 1 | 1 while the display is awake |
| status | output | 8 | Status byte, bit 6 = asleep |
| locked | output | 1 | 1 while the gate is closed |

## Verification
The clashes that matter are a pixel-data byte arriving in the very cycle in which a pending command would have completed, and a closed gate meeting bytes that would otherwise write settings. The bench sends a pixel-data byte in place of a window's second byte and partway through a table load. It requires no strobe and unchanged windows. It also requires that the next command byte be decoded as a fresh opcode. With the gate closed, it replays every writing opcode with its argument and checks that all outputs hold until the opening sequence is sent.

// File: rtl/dcmd_parser.sv
module dcmd_parser #(
  parameter int NSLOT   = 18,
  parameter int NICON   = 64,
  parameter int NGRAY   = 15,
  parameter int MUX_MIN = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_dc,
  input  logic [7:0]            in_byte,
  output logic [NSLOT-1:0][7:0] cfg_regs,
  output logic [7:0]            col_start,
  output logic [7:0]            col_end,
  output logic [7:0]            row_start,
  output logic [7:0]            row_end,
  output logic                  col_load,
  output logic                  row_load,
  output logic                  lut_we,
  output logic                  lut_tbl,
  output logic [5:0]            lut_addr,
  output logic [7:0]            lut_data,
  output logic                  gray_default,
  output logic [1:0]            disp_mode,
  output logic                  disp_on,
  output logic [7:0]            status,
  output logic                  locked
);
  localparam int MUX_SLOT = 11;
  localparam logic [4:0] NO_SLOT = 5'd31;

  logic [7:0] op, stage;
  logic [6:0] remain, idx;

  function automatic logic [4:0] slot_of(input logic [7:0] b);
    case (b)
      8'h81: slot_of = 5'd0;   8'h82: slot_of = 5'd1;
      8'h90: slot_of = 5'd2;   8'h91: slot_of = 5'd3;
      8'h93: slot_of = 5'd4;   8'h94: slot_of = 5'd5;
      8'h95: slot_of = 5'd6;   8'h96: slot_of = 5'd7;
      8'hA0: slot_of = 5'd8;   8'hA1: slot_of = 5'd9;
      8'hA2: slot_of = 5'd10;  8'hA8: slot_of = 5'd11;
      8'hB1: slot_of = 5'd12;  8'hB2: slot_of = 5'd13;
      8'hB3: slot_of = 5'd14;  8'hBB: slot_of = 5'd15;
      8'hBC: slot_of = 5'd16;  8'hBE: slot_of = 5'd17;
      default: slot_of = NO_SLOT;
    endcase
  endfunction

  function automatic logic [6:0] nargs(input logic [7:0] b);
    case (b)
      8'h15, 8'h75: nargs = 7'd2;
      8'h92:        nargs = 7'(NICON);
      8'hB8:        nargs = 7'(NGRAY);
      8'hFD:        nargs = 7'd1;
      default:      nargs = (slot_of(b) != NO_SLOT) ? 7'd1 : 7'd0;
    endcase
  endfunction

  wire is_arg    = in_valid && !in_dc && remain != 0;
  wire is_opcode = in_valid && !in_dc && remain == 0 && (!locked || in_byte == 8'hFD);
  wire [6:0] mux_v = (in_byte[6:0] < 7'(MUX_MIN)) ? 7'(MUX_MIN) : in_byte[6:0];

  assign status = {1'b0, ~disp_on, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_regs     <= '0;
      cfg_regs[MUX_SLOT] <= 8'd127;
      {col_start, col_end, row_start, row_end} <= '0;
      {col_load, row_load, lut_we, lut_tbl, gray_default} <= '0;
      lut_addr <= '0;  lut_data <= '0;
      disp_mode <= 2'd0;  disp_on <= 1'b0;  locked <= 1'b0;
      op <= '0;  stage <= '0;  remain <= '0;  idx <= '0;
    end else begin
      col_load <= 1'b0;  row_load <= 1'b0;  lut_we <= 1'b0;  gray_default <= 1'b0;
      if (in_valid && in_dc) begin
        remain <= '0;
      end else if (is_arg) begin
        remain <= remain - 7'd1;
        idx    <= idx + 7'd1;
        case (op)
          8'h15: if (idx == 0) stage <= in_byte;
                 else begin col_start <= stage; col_end <= in_byte; col_load <= 1'b1; end
          8'h75: if (idx == 0) stage <= in_byte;
                 else begin row_start <= stage; row_end <= in_byte; row_load <= 1'b1; end
          8'h92: begin lut_we <= 1'b1; lut_tbl <= 1'b0; lut_addr <= idx[5:0]; lut_data <= in_byte; end
          8'hB8: begin lut_we <= 1'b1; lut_tbl <= 1'b1; lut_addr <= idx[5:0] + 6'd1; lut_data <= in_byte; end
          8'hFD: if (in_byte == 8'h12) locked <= 1'b0;
                 else if (in_byte == 8'h13) locked <= 1'b1;
          default:
            if (slot_of(op) == 5'(MUX_SLOT)) cfg_regs[MUX_SLOT] <= {1'b0, mux_v};
            else if (slot_of(op) != NO_SLOT) cfg_regs[slot_of(op)] <= in_byte;
        endcase
      end else if (is_opcode) begin
        op     <= in_byte;
        remain <= nargs(in_byte);
        idx    <= '0;
        case (in_byte)
          8'hA4, 8'hA5, 8'hA6, 8'hA7: disp_mode <= in_byte[1:0];
          8'hAE: disp_on <= 1'b0;
          8'hAF: disp_on <= 1'b1;
          8'hB7: gray_default <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  p_gray_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_we && lut_tbl) |-> (lut_addr >= 6'd1 && lut_addr <= 6'(NGRAY)));

  p_locked_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && in_valid && (in_dc || (remain == 0 && in_byte != 8'hFD)))
      |=> ($stable(cfg_regs) && $stable(disp_on) && $stable(disp_mode)
           && !lut_we && !col_load && !row_load));

  p_mux_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_regs[MUX_SLOT] >= 8'(MUX_MIN) && !cfg_regs[MUX_SLOT][7]);

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dc) |=> (!lut_we && !col_load && !row_load && $stable(cfg_regs)));

  p_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_opcode && in_byte == 8'hAE) |=> !disp_on && status[6]);

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({col_load, row_load, lut_we}));
endmodule

// File: tb/sim_dcmd_parser.sv
`timescale 1ns/1ps
module sim_dcmd_parser;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_dc = 1'b0;
  logic [7:0] in_byte = '0;
  logic [17:0][7:0] cfg_regs;
  logic [7:0] col_start, col_end, row_start, row_end, lut_data, status;
  logic col_load, row_load, lut_we, lut_tbl, gray_default, disp_on, locked;
  logic [5:0] lut_addr;
  logic [1:0] disp_mode;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [17:0][7:0] exp_cfg;
  localparam logic [7:0] OPS [18] = '{8'h81, 8'h82, 8'h90, 8'h91, 8'h93, 8'h94,
    8'h95, 8'h96, 8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hB1, 8'hB2, 8'hB3, 8'hBB, 8'hBC, 8'hBE};

  dcmd_parser u0 (.clk, .rst_n, .in_valid, .in_dc, .in_byte, .cfg_regs,
    .col_start, .col_end, .row_start, .row_end, .col_load, .row_load,
    .lut_we, .lut_tbl, .lut_addr, .lut_data, .gray_default, .disp_mode,
    .disp_on, .status, .locked);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic dc, input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_dc = dc; in_byte = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  function automatic bit known(input logic [7:0] b);
    if (b inside {8'h15, 8'h75, 8'h92, 8'hB8, 8'hFD, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
                  8'hAE, 8'hAF, 8'hB7}) return 1;
    foreach (OPS[i]) if (OPS[i] == b) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] mux_exp(input logic [7:0] v);
    return (v[6:0] < 15) ? 8'd15 : {1'b0, v[6:0]};
  endfunction

  task automatic quiet(input string req);
    chk(!col_load && !row_load && !lut_we && !gray_default, req,
        {col_load, row_load, lut_we, gray_default}, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_cfg = '0; exp_cfg[11] = 8'd127;
    // R1 reset state
    chk(cfg_regs == exp_cfg, "R1 cfg", cfg_regs[11], 127);
    chk({col_start, col_end, row_start, row_end} == 0, "R1 windows",
        {col_start, col_end, row_start, row_end}, 0);
    chk(!disp_on && status == 8'h40 && !locked, "R1 status", status, 8'h40);
    quiet("R1 strobes");

    // R3 one-argument slots, R10 line-count floor
    for (int s = 0; s < 18; s++) begin
      logic [7:0] v;
      v = 8'(8'hC3 ^ (s * 37));
      send(0, OPS[s]); send(0, v);
      exp_cfg[s] = (s == 11) ? mux_exp(v) : v;
      chk(cfg_regs == exp_cfg, "R3 slot write", cfg_regs[s], exp_cfg[s]);
    end
    for (int v = 0; v < 256; v += 3) begin
      send(0, 8'hA8); send(0, 8'(v));
      exp_cfg[11] = mux_exp(8'(v));
      chk(cfg_regs[11] == exp_cfg[11], "R10 line count", cfg_regs[11], exp_cfg[11]);
    end

    // R2 windows: strobe only after the second byte
    send(0, 8'h15); send(0, 8'h07);
    chk(!col_load && col_start == 0, "R2 col first byte", col_start, 0);
    send(0, 8'h3A);
    chk(col_load && col_start == 8'h07 && col_end == 8'h3A, "R2 col window",
        {col_load, col_start, col_end}, {1'b1, 8'h07, 8'h3A});
    @(negedge clk);
    chk(!col_load, "R2 col pulse width", col_load, 0);
    send(0, 8'h75); send(0, 8'h11); send(0, 8'h7F);
    chk(row_load && row_start == 8'h11 && row_end == 8'h7F && !col_load, "R2 row window",
        {row_load, row_start, row_end}, {1'b1, 8'h11, 8'h7F});

    // R4 icon table
    send(0, 8'h92);
    for (int k = 0; k < 64; k++) begin
      send(0, 8'(k * 3 + 1));
      chk(lut_we && !lut_tbl && lut_addr == 6'(k) && lut_data == 8'(k * 3 + 1),
          "R4 icon write", {lut_we, lut_tbl, lut_addr, lut_data},
          {1'b1, 1'b0, 6'(k), 8'(k * 3 + 1)});
    end
    send(0, 8'hAF);
    chk(disp_on && !lut_we, "R4 table ends after 64", {disp_on, lut_we}, 2'b10);

    // R5 gray table
    send(0, 8'hB8);
    for (int k = 0; k < 15; k++) begin
      send(0, 8'(k + 40));
      chk(lut_we && lut_tbl && lut_addr == 6'(k + 1) && lut_data == 8'(k + 40),
          "R5 gray write", {lut_we, lut_tbl, lut_addr, lut_data},
          {1'b1, 1'b1, 6'(k + 1), 8'(k + 40)});
    end
    send(0, 8'hAE);
    chk(!disp_on && !lut_we, "R5 table ends after 15", {disp_on, lut_we}, 0);

    // R6 sleep and status
    chk(status == 8'h40, "R6 asleep status", status, 8'h40);
    send(0, 8'hAF);
    chk(disp_on && status == 8'h00, "R6 awake status", status, 0);

    // R7 display modes and default gray pulse
    for (int m = 3; m >= 0; m--) begin
      send(0, 8'(8'hA4 + m));
      chk(disp_mode == 2'(m), "R7 display mode", disp_mode, m);
    end
    send(0, 8'hB7);
    chk(gray_default, "R7 default gray pulse", gray_default, 1);
    @(negedge clk);
    chk(!gray_default, "R7 pulse width", gray_default, 0);

    // R11 unknown opcodes are no-ops
    for (int b = 0; b < 256; b++) begin
      if (!known(8'(b))) begin
        send(0, 8'(b)); send(0, 8'h81); send(0, 8'(b ^ 8'h5A));
        exp_cfg[0] = 8'(b ^ 8'h5A);
        chk(cfg_regs == exp_cfg && disp_on, "R11 unknown opcode", cfg_regs[0], exp_cfg[0]);
      end
    end

    // R12 abort by pixel-data byte
    send(0, 8'h15); send(0, 8'h22); send(1, 8'h33);
    chk(!col_load && col_start == 8'h07 && col_end == 8'h3A, "R12 window abort",
        {col_start, col_end}, {8'h07, 8'h3A});
    send(0, 8'h81); send(0, 8'h77); exp_cfg[0] = 8'h77;
    chk(cfg_regs == exp_cfg && !col_load, "R12 fresh opcode", cfg_regs[0], 8'h77);
    send(0, 8'h92);
    for (int k = 0; k < 10; k++) send(0, 8'(k));
    send(1, 8'hEE);
    quiet("R12 table abort");
    send(0, 8'hAE);
    chk(!disp_on && !lut_we, "R12 opcode after table abort", {disp_on, lut_we}, 0);
    send(1, 8'h81);
    chk(cfg_regs == exp_cfg && !disp_on, "R12 idle data ignored", cfg_regs[0], exp_cfg[0]);

    // R8 / R9 gate
    send(0, 8'hFD); send(0, 8'h14);
    chk(!locked, "R8 other arg keeps open", locked, 0);
    send(0, 8'hFD); send(0, 8'h13);
    chk(locked, "R8 close", locked, 1);
    for (int s = 0; s < 18; s++) begin
      send(0, OPS[s]); send(0, 8'h99);
      chk(cfg_regs == exp_cfg, "R9 slot dropped", cfg_regs[s], exp_cfg[s]);
    end
    send(0, 8'h15); send(0, 8'h01); send(0, 8'h02);
    quiet("R9 window dropped");
    send(0, 8'h92); send(0, 8'h05);
    quiet("R9 table dropped");
    send(0, 8'hAF); send(0, 8'hA7); send(1, 8'h12); send(0, 8'h12);
    chk(!disp_on && disp_mode == 2'd0 && locked, "R9 mode/sleep/unlock byte dropped",
        {disp_on, disp_mode, locked}, 3'b001);
    send(0, 8'hFD); send(0, 8'h16);
    chk(locked, "R8 other arg keeps closed", locked, 1);
    send(0, 8'hFD); send(0, 8'h12);
    chk(!locked, "R8 open", locked, 0);
    send(0, 8'h82); send(0, 8'h44); exp_cfg[1] = 8'h44;
    chk(cfg_regs == exp_cfg, "R9 writes resume", cfg_regs[1], 8'h44);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule